// File: doc/BRIEF.md
# Two-Wire EEPROM Random-Read Master

This block fetches a single byte from a serial EEPROM. It drives the bus by toggling a clock line and a data line, one level change at a time. It also drives an enable line and reads the returned data on a separate input. A request carries a word address. The block then does three things in order:

- It sends a dummy write: the write command, then the word address.
- It sends the read command.
- It clocks in eight data bits, most significant first, and then polls for the closing not-acknowledge.

Every line update is held for a fixed number of clock cycles before the next one, which gives the slow device time to settle.

Both command sends are repeated when the device does not acknowledge. Each command gets its own budget of attempts. Acknowledge polling is bounded. When any phase runs out of attempts or polls, the transaction ends at once and returns 0xFF. The result comes back as a one-cycle valid pulse. While a transaction is running, further requests are ignored. No stop condition is ever produced.

Top module: `eerd_master`

## Requirements
- R1: Out of reset, and whenever no transaction runs, the outputs read enable 0, clock 0, data 1 and valid 0.
- R2: During a transaction the enable line is 1, and each (clock, data) step stays on the lines for exactly SETTLE_CYC cycles. The first step appears at the clock edge that accepts the request.
- R3: A start condition is the step sequence (0,1), (1,1), (1,0), (0,1).
- R4: A byte is sent as eight bits, bit 7 first. Each bit is three steps that keep data at the bit value while the clock goes 0, 1, 0.
- R5: A bit read is the steps (0,1), (1,1), (1,1), (0,1). The data input is sampled in the last cycle of the second step.
- R6: An acknowledge is a sampled 0. Up to POLL_MAX bit reads are made for it, and a 0 ends the polling at once.
- R7: A command send is a start, the command byte and acknowledge polling. If it gets no acknowledge, the whole send is repeated, up to RETRY_MAX attempts. The write command (WR_CMD) comes first, the read command (RD_CMD) later, and each has its own attempt budget.
- R8: The word address byte follows the acknowledged write command. It is polled once, with no repeat, and a missing acknowledge ends the transaction with 0xFF.
- R9: After the read command is acknowledged, eight bit reads form the result, MSB first. Up to POLL_MAX further reads are then made looking for a sampled 1. If no 1 arrives, the result is 0xFF.
- R10: The cycle after the last step, valid is 1 for one cycle with the result, and the lines return to the idle levels in that same cycle. Any exhausted attempt or poll budget yields 0xFF.
- R11: A request that arrives during a transaction has no effect on the lines or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a read; taken only when idle |
| addr_i | input | 8 | Word address, sampled with the request |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | 8 | Result byte, 0xFF on failure |
| scl_o | output | 1 | Bus clock level |
| sda_o | output | 1 | Bus data level driven (1 = released) |
| en_o | output | 1 | Bus drive enable |
| sda_i | input | 1 | Bus data level read back |

## Verification
Almost any wrong internal state shows up on the bus lines within one settle period:

- A wrong phase or sub-step puts a wrong (clock, data) pair on the lines.
- A wrong bit index flips a transmitted bit.
- An off-by-one in an attempt or poll counter adds or drops a whole four-step bit read before the next start or the result.

A wrong sampling point or a wrong shift order can only be seen at the valid strobe, where it shows as a wrong result byte or a missing 0xFF substitution. The bench therefore compares the lines on every cycle against a behavioural model. That model scripts how the device responds, and the bench checks the result byte when valid pulses.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_WSTART,
    PH_WCMD,
    PH_WACK,
    PH_ADDR,
    PH_AACK,
    PH_RSTART,
    PH_RCMD,
    PH_RACK,
    PH_RDATA,
    PH_NACK
  } phase_e;

  typedef struct packed {
    logic scl;
    logic sda;
  } step_t;

  function automatic logic is_start(phase_e ph);
    return (ph == PH_WSTART) || (ph == PH_RSTART);
  endfunction

  function automatic logic is_wbyte(phase_e ph);
    return (ph == PH_WCMD) || (ph == PH_ADDR) || (ph == PH_RCMD);
  endfunction

  function automatic logic is_rbit(phase_e ph);
    return (ph == PH_WACK) || (ph == PH_AACK) || (ph == PH_RACK) ||
           (ph == PH_RDATA) || (ph == PH_NACK);
  endfunction

  // index of the final sub-step of one unit (start, sent bit, read bit)
  function automatic logic [1:0] last_sub(phase_e ph);
    return is_wbyte(ph) ? 2'd2 : 2'd3;
  endfunction

  // bit idx 0 is the most significant bit
  function automatic logic pick_bit(logic [BYTE_W-1:0] v, logic [2:0] idx);
    return v[3'd7 - idx];
  endfunction

  function automatic logic [BYTE_W-1:0] shift_in(logic [BYTE_W-1:0] acc, logic b);
    return {acc[BYTE_W-2:0], b};
  endfunction

  function automatic step_t step_for(phase_e ph, logic [1:0] sub, logic bitv);
    step_t s;
    s.scl = 1'b0;
    s.sda = 1'b1;
    if (is_start(ph)) begin
      s.scl = (sub == 2'd1) || (sub == 2'd2);
      s.sda = (sub != 2'd2);
    end else if (is_wbyte(ph)) begin
      s.scl = (sub == 2'd1);
      s.sda = bitv;
    end else if (is_rbit(ph)) begin
      s.scl = (sub == 2'd1) || (sub == 2'd2);
      s.sda = 1'b1;
    end
    return s;
  endfunction

endpackage

// File: rtl/eerd_pacer.sv
module eerd_pacer #(
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue_i,
  input  logic           release_i,
  input  eerd_pkg::step_t step_i,
  input  logic           sample_en_i,
  input  logic           sda_i,
  output logic           scl_o,
  output logic           sda_o,
  output logic           en_o,
  output logic           ready_o,
  output logic           step_end_o,
  output logic           samp_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign ready_o    = (cnt_q <= CW'(1));
  assign step_end_o = (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      en_o   <= 1'b0;
      scl_o  <= 1'b0;
      sda_o  <= 1'b1;
      samp_o <= 1'b1;
    end else begin
      if (issue_i) begin
        en_o  <= 1'b1;
        scl_o <= step_i.scl;
        sda_o <= step_i.sda;
        cnt_q <= CW'(SETTLE_CYC);
      end else if (release_i) begin
        en_o  <= 1'b0;
        scl_o <= 1'b0;
        sda_o <= 1'b1;
        cnt_q <= '0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CW'(1);
      end
      if (step_end_o && sample_en_i) samp_o <= sda_i;
    end
  end
endmodule

// File: rtl/eerd_limit_ctr.sv
module eerd_limit_ctr #(
  parameter int unsigned LIMIT = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr_i,
  input  logic                           inc_i,
  output logic [$clog2(LIMIT+1)-1:0]     val_o,
  output logic                           last_o
);
  localparam int unsigned VW = $clog2(LIMIT + 1);

  assign last_o = (val_o == VW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_o <= '0;
    else if (clr_i)  val_o <= '0;
    else if (inc_i)  val_o <= val_o + VW'(1);
  end
endmodule

// File: rtl/eerd_master.sv
module eerd_master #(
  parameter int unsigned SETTLE_CYC = 8,
  parameter logic [7:0]  WR_CMD     = 8'hA0,
  parameter logic [7:0]  RD_CMD     = 8'hA1,
  parameter int unsigned RETRY_MAX  = 10,
  parameter int unsigned POLL_MAX   = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic [7:0] addr_i,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       scl_o,
  output logic       sda_o,
  output logic       en_o,
  input  logic       sda_i
);
  import eerd_pkg::*;

  localparam int unsigned RVW = $clog2(RETRY_MAX + 1);
  localparam int unsigned PVW = $clog2(POLL_MAX + 1);

  phase_e       phase_q, nph;
  logic [1:0]   sub_q, nsub;
  logic [2:0]   bit_q, nbit;
  logic [7:0]   addr_q, shreg_q;

  // named internal events
  logic accept, adv, issue, fin_ok, fin_fail, sh_shift;
  logic retry_clr, retry_inc, poll_clr, poll_inc;
  logic ready, step_end, samp, sample_en;
  logic retry_last, poll_last;
  logic [RVW-1:0] retry_val;
  logic [PVW-1:0] poll_val;
  logic [7:0] nbyte;
  step_t      nstep;

  assign accept    = (phase_q == PH_IDLE) && req_i;
  assign adv       = (phase_q != PH_IDLE) && ready;
  assign sample_en = is_rbit(phase_q) && (sub_q == 2'd1);

  eerd_pacer #(.SETTLE_CYC(SETTLE_CYC)) u_pacer (
    .clk(clk), .rst_n(rst_n),
    .issue_i(issue), .release_i(fin_ok | fin_fail),
    .step_i(nstep), .sample_en_i(sample_en), .sda_i(sda_i),
    .scl_o(scl_o), .sda_o(sda_o), .en_o(en_o),
    .ready_o(ready), .step_end_o(step_end), .samp_o(samp)
  );

  eerd_limit_ctr #(.LIMIT(RETRY_MAX)) u_retry (
    .clk(clk), .rst_n(rst_n), .clr_i(retry_clr), .inc_i(retry_inc),
    .val_o(retry_val), .last_o(retry_last)
  );

  eerd_limit_ctr #(.LIMIT(POLL_MAX)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr_i(poll_clr), .inc_i(poll_inc),
    .val_o(poll_val), .last_o(poll_last)
  );

  // byte on the wire for the phase about to be entered
  always_comb begin
    case (nph)
      PH_WCMD: nbyte = WR_CMD;
      PH_ADDR: nbyte = accept ? addr_i : addr_q;
      default: nbyte = RD_CMD;
    endcase
    nstep = step_for(nph, nsub, pick_bit(nbyte, nbit));
  end

  always_comb begin
    nph = phase_q; nsub = sub_q; nbit = bit_q;
    issue = 1'b0; fin_ok = 1'b0; fin_fail = 1'b0; sh_shift = 1'b0;
    retry_clr = 1'b0; retry_inc = 1'b0; poll_clr = 1'b0; poll_inc = 1'b0;
    if (accept) begin
      nph = PH_WSTART; nsub = 2'd0; nbit = 3'd0;
      issue = 1'b1; retry_clr = 1'b1; poll_clr = 1'b1;
    end else if (adv) begin
      if (sub_q != last_sub(phase_q)) begin
        nsub = sub_q + 2'd1;
        issue = 1'b1;
      end else begin
        nsub = 2'd0;
        case (phase_q)
          PH_WSTART, PH_RSTART: begin
            nph   = (phase_q == PH_WSTART) ? PH_WCMD : PH_RCMD;
            nbit  = 3'd0;
            issue = 1'b1;
          end
          PH_WCMD, PH_ADDR, PH_RCMD: begin
            issue = 1'b1;
            if (bit_q == 3'd7) begin
              poll_clr = 1'b1;
              case (phase_q)
                PH_WCMD: nph = PH_WACK;
                PH_ADDR: nph = PH_AACK;
                default: nph = PH_RACK;
              endcase
            end else begin
              nbit = bit_q + 3'd1;
            end
          end
          PH_WACK, PH_RACK: begin
            if (!samp) begin
              issue = 1'b1; poll_clr = 1'b1; nbit = 3'd0;
              nph = (phase_q == PH_WACK) ? PH_ADDR : PH_RDATA;
            end else if (!poll_last) begin
              issue = 1'b1; poll_inc = 1'b1;
            end else if (!retry_last) begin
              issue = 1'b1; poll_clr = 1'b1; retry_inc = 1'b1;
              nph = (phase_q == PH_WACK) ? PH_WSTART : PH_RSTART;
            end else begin
              fin_fail = 1'b1; nph = PH_IDLE;
            end
          end
          PH_AACK: begin
            if (!samp) begin
              issue = 1'b1; poll_clr = 1'b1; retry_clr = 1'b1;
              nph = PH_RSTART;
            end else if (!poll_last) begin
              issue = 1'b1; poll_inc = 1'b1;
            end else begin
              fin_fail = 1'b1; nph = PH_IDLE;
            end
          end
          PH_RDATA: begin
            sh_shift = 1'b1; issue = 1'b1;
            if (bit_q == 3'd7) begin
              nph = PH_NACK; poll_clr = 1'b1;
            end else begin
              nbit = bit_q + 3'd1;
            end
          end
          PH_NACK: begin
            if (samp) begin
              fin_ok = 1'b1; nph = PH_IDLE;
            end else if (!poll_last) begin
              issue = 1'b1; poll_inc = 1'b1;
            end else begin
              fin_fail = 1'b1; nph = PH_IDLE;
            end
          end
          default: nph = PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sub_q   <= 2'd0;
      bit_q   <= 3'd0;
      addr_q  <= 8'h00;
      shreg_q <= 8'h00;
      valid_o <= 1'b0;
      data_o  <= 8'hFF;
    end else begin
      phase_q <= nph;
      sub_q   <= nsub;
      bit_q   <= nbit;
      if (accept)   addr_q  <= addr_i;
      if (sh_shift) shreg_q <= shift_in(shreg_q, samp);
      valid_o <= fin_ok | fin_fail;
      if (fin_fail)    data_o <= 8'hFF;
      else if (fin_ok) data_o <= shreg_q;
    end
  end
endmodule

// File: rtl/eerd_master_chk.sv
module eerd_master_chk #(
  parameter int unsigned RETRY_MAX = 10,
  parameter int unsigned POLL_MAX  = 10
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           en_o,
  input logic                           scl_o,
  input logic                           sda_o,
  input logic                           valid_o,
  input logic [7:0]                     data_o,
  input logic                           step_end,
  input logic                           accept,
  input logic                           fin_fail,
  input logic [$clog2(RETRY_MAX+1)-1:0] retry_val,
  input logic [$clog2(POLL_MAX+1)-1:0]  poll_val
);
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> (!scl_o && sda_o));

  p_change_on_step_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({en_o, scl_o, sda_o}) |-> $past(step_end || accept));

  p_poll_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(poll_val) < POLL_MAX);

  p_retry_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(retry_val) < RETRY_MAX);

  p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_valid_idle_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !en_o);

  p_fail_gives_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_fail |=> (valid_o && data_o == 8'hFF));
endmodule

bind eerd_master eerd_master_chk #(.RETRY_MAX(RETRY_MAX), .POLL_MAX(POLL_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_o(en_o), .scl_o(scl_o), .sda_o(sda_o),
  .valid_o(valid_o), .data_o(data_o), .step_end(step_end), .accept(accept),
  .fin_fail(fin_fail), .retry_val(retry_val), .poll_val(poll_val)
);

// File: tb/sim_eerd_master.sv
module sim_eerd_master;
  localparam int unsigned SETTLE = 3;
  localparam logic [7:0]  WRC    = 8'hA0;
  localparam logic [7:0]  RDC    = 8'hA1;
  localparam int          TRIES  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic sda_i = 1'b1;
  logic valid_o, scl_o, sda_o, en_o;
  logic [7:0] data_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [2:0] q_line[$];
  bit         q_drv[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  eerd_master #(.SETTLE_CYC(SETTLE), .WR_CMD(WRC), .RD_CMD(RDC),
                .RETRY_MAX(TRIES), .POLL_MAX(TRIES)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
    .valid_o(valid_o), .data_o(data_o), .scl_o(scl_o), .sda_o(sda_o),
    .en_o(en_o), .sda_i(sda_i)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // expected line triple is {en, clock, data}; each step lasts SETTLE cycles
  task automatic put(bit c, bit d, bit drv, string tag);
    for (int k = 0; k < SETTLE; k++) begin
      q_line.push_back({1'b1, c, d});
      q_drv.push_back(drv);
      q_tag.push_back(tag);
    end
  endtask

  task automatic put_start();
    put(0, 1, 1, "R3"); put(1, 1, 1, "R3"); put(1, 0, 1, "R3"); put(0, 1, 1, "R3");
  endtask

  task automatic put_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      put(0, b[i], 1, "R4"); put(1, b[i], 1, "R4"); put(0, b[i], 1, "R4");
    end
  endtask

  task automatic put_read(bit resp, string tag);
    put(0, 1, resp, tag); put(1, 1, resp, tag); put(1, 1, resp, tag); put(0, 1, resp, tag);
  endtask

  // device answers with 0 on poll number k; k >= TRIES means never
  task automatic put_ack_poll(int k, string tag, output bit got);
    got = 1'b0;
    for (int i = 0; i < TRIES; i++) begin
      if (i == k) begin put_read(0, tag); got = 1'b1; break; end
      put_read(1, tag);
    end
  endtask

  task automatic put_command(logic [7:0] cmd, int fails, int k, output bit got);
    got = 1'b0;
    for (int a = 0; a < TRIES; a++) begin
      put_start();
      put_byte(cmd);
      if (a < fails) put_ack_poll(TRIES, "R7", got);
      else begin put_ack_poll(k, "R6", got); break; end
    end
  endtask

  task automatic build(logic [7:0] a, int wfail, int wk, int ak, int rfail, int rk,
                       logic [7:0] d, int nk, output logic [7:0] res);
    bit ok;
    res = 8'hFF;
    put_command(WRC, wfail, wk, ok);
    if (!ok) return;
    put_byte(a);
    put_ack_poll(ak, "R8", ok);
    if (!ok) return;
    put_command(RDC, rfail, rk, ok);
    if (!ok) return;
    for (int i = 7; i >= 0; i--) put_read(d[i], "R9");
    for (int i = 0; i < TRIES; i++) begin
      if (i == nk) begin put_read(1, "R9"); res = d; return; end
      put_read(0, "R9");
    end
  endtask

  task automatic run_case(string tag, logic [7:0] a, int wfail, int wk, int ak,
                          int rfail, int rk, logic [7:0] d, int nk);
    logic [7:0] exp;
    int idx;
    build(a, wfail, wk, ak, rfail, rk, d, nk, exp);
    @(negedge clk);
    req_i = 1'b1; addr_i = a;
    idx = 0;
    while (q_line.size() != 0) begin
      logic [2:0] e;
      string t;
      @(negedge clk);
      e = q_line.pop_front();
      t = q_tag.pop_front();
      // R11: a second request mid-transaction must leave the lines untouched
      req_i  = (idx == 5);
      addr_i = (idx == 5) ? ~a : a;
      chk({en_o, scl_o, sda_o} == e && !valid_o, t, "lines{en,scl,sda,valid}",
          {en_o, scl_o, sda_o, valid_o}, {e, 1'b0});
      sda_i = q_drv.pop_front();
      idx++;
    end
    @(negedge clk);
    sda_i = 1'b1;
    chk(valid_o == 1'b1, "R10", "valid at end", valid_o, 1);
    chk(data_o == exp, tag, "result byte", data_o, exp);
    chk({en_o, scl_o, sda_o} == 3'b001, "R1", "idle lines after result",
        {en_o, scl_o, sda_o}, 3'b001);
    @(negedge clk);
    chk(valid_o == 1'b0, "R10", "valid single cycle", valid_o, 0);
    chk({en_o, scl_o, sda_o} == 3'b001, "R11", "no second transaction",
        {en_o, scl_o, sda_o}, 3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({en_o, scl_o, sda_o, valid_o} == 4'b0010, "R1", "reset outputs",
        {en_o, scl_o, sda_o, valid_o}, 4'b0010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({en_o, scl_o, sda_o, valid_o} == 4'b0010, "R1", "idle outputs",
        {en_o, scl_o, sda_o, valid_o}, 4'b0010);
    run_case("R2", 8'h15, 0, 0, 0, 0, 0, 8'hA5, 0);
    run_case("R6", 8'hC3, 0, 3, 9, 0, 2, 8'h3C, 9);
    run_case("R7", 8'h80, 2, 1, 0, 0, 0, 8'h81, 0);
    run_case("R7", 8'h01, 0, 0, 0, 9, 9, 8'h5A, 1);
    run_case("R7", 8'h7E, 10, 0, 0, 0, 0, 8'h12, 0);
    run_case("R8", 8'h42, 0, 0, 10, 0, 0, 8'h12, 0);
    run_case("R7", 8'h24, 0, 0, 0, 10, 0, 8'h12, 0);
    run_case("R9", 8'hEE, 0, 0, 0, 0, 0, 8'h12, 10);
    run_case("R5", 8'h00, 1, 0, 4, 1, 0, 8'h00, 3);
    run_case("R4", 8'hFF, 0, 9, 0, 0, 0, 8'h96, 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule